// File: doc/BRIEF.md
# Card Interface Interrupt Status Unit

This block gathers the event and error indications of a memory-card host controller into one 32-bit status word. From that word and a software-owned mask it derives a single interrupt line. The command and data engines that raise the events sit outside the block and drive a 32-bit event vector.

The low half of the status word carries condition bits, and these follow the event inputs directly. The high half carries error bits. Each error bit latches on a one-cycle pulse and stays set until software reads the status word. Because every error sits in the upper half, one masked test of bits 31..16 tells software whether an operation failed.

The mask cannot be written as a whole word. Software sets mask bits by writing ones to one register and clears them by writing ones to a second register. A third register returns the current mask.

Register offsets:

| Offset | Access | Purpose |
|--------|--------|---------|
| 0x40 | read | status word |
| 0x44 | write | set mask bits |
| 0x48 | write | clear mask bits |
| 0x4C | read | mask readback |

Top module: `card_evt_irq`

## Requirements
- R1: After reset the mask is zero, all captured error bits are zero, `irq` is low and `bus_rdata` is zero.
- R2: Status bits 0 (command ready), 1 (receiver ready), 2 (transmitter ready), 3 (block ended), 4 (transfer in progress), 5 (not busy), 6 (receive DMA end), 7 (transmit DMA end), 14 (receive buffer full) and 15 (transmit buffer empty) are live. A status read returns the value `evt_in` has in the read cycle, and nothing is latched.
- R3: Status bits 16 (response index), 17 (response direction), 18 (response CRC), 19 (response end bit), 20 (response timeout), 21 (data CRC), 22 (data timeout), 30 (overrun) and 31 (underrun) are sticky. Each one sets on a one-cycle pulse of the matching `evt_in` bit and stays set through any access other than a status read.
- R4: A status read at offset 0x40 returns the captured error bits and clears them. An error pulse that arrives in the same cycle as that read is left out of the returned value but remains set for the next read.
- R5: Writing ones to offset 0x44 sets those mask bits and leaves the others unchanged. Writing ones to offset 0x48 clears those mask bits, and writing all ones there clears the whole mask. The mask reads back at offset 0x4C.
- R6: Writes to offsets 0x40 and 0x4C have no effect on either the mask or the captured error bits.
- R7: Bit positions 8–13 and 23–29 are unimplemented. They always read as zero in both the status word and the mask, whatever is driven on `evt_in` or written to the mask registers.
- R8: `irq` is high exactly when some status bit and its mask bit are both set. A live bit affects `irq` in the same cycle. An error bit affects `irq` from the clock edge that captures it, and a mask write affects `irq` from the edge that performs the write.
- R9: Read data appears on `bus_rdata` one clock edge after the read request. Reads of 0x44, 0x48 or any unmapped offset return zero, and `bus_rdata` is zero in every cycle that follows a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (8) | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_in | input | 32 | Event vector: levels in bits 15..0, one-cycle error pulses in bits 31..16 |
| irq | output | 1 | Interrupt line, OR of status AND mask |

## Verification
Each result has its own due time:
- Read data is due one edge after the read request. The bench therefore raises the strobe at a falling edge and samples at the next falling edge.
- Error captures and mask writes take effect at the edge after their stimulus. Live bits reach `irq` with no edge at all, so `irq` is sampled 1 ns after the inputs change.
- The clear-on-read collision case needs two status reads in sequence. The first read must omit the colliding error bit and the second must show it.

Sweeps walk a single set bit through all 32 positions for mask set, mask clear, live status, error capture and interrupt. Expected words come from the implemented-bit lists in the requirements.

// File: rtl/cei_pkg.sv
package cei_pkg;
   localparam int WORD_W = 32;
   typedef logic [WORD_W-1:0] word_t;

   // live condition positions: 0..7, 14, 15
   localparam word_t LIVE_BITS = 32'h0000_C0FF;
   // sticky error positions: 16..22, 30, 31
   localparam word_t ERR_BITS  = 32'hC07F_0000;

   localparam logic [7:0] DEF_OFS_STAT = 8'h40;
   localparam logic [7:0] DEF_OFS_SET  = 8'h44;
   localparam logic [7:0] DEF_OFS_CLR  = 8'h48;
   localparam logic [7:0] DEF_OFS_MASK = 8'h4C;
endpackage

// File: rtl/cei_live.sv
module cei_live #(
   parameter int          W    = 32,
   parameter logic [W-1:0] KEEP = '0,
   parameter bit          SYNC = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   output logic [W-1:0] lvl_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (!KEEP[i]) begin : g_off
         assign lvl_o[i] = 1'b0;
      end else if (SYNC) begin : g_reg
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= evt_i[i];
         end
         assign lvl_o[i] = q;
      end else begin : g_comb
         assign lvl_o[i] = evt_i[i];
      end
   end
endmodule

// File: rtl/cei_sticky.sv
module cei_sticky #(
   parameter int          W    = 32,
   parameter logic [W-1:0] KEEP = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_i,
   output logic [W-1:0] flag_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (KEEP[i]) begin : g_on
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n)        q <= 1'b0;
            else if (set_i[i]) q <= 1'b1;
            else if (clr_i)    q <= 1'b0;
         end
         assign flag_o[i] = q;
      end else begin : g_off
         assign flag_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/cei_mask.sv
module cei_mask #(
   parameter int          W    = 32,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] mask_o
);
   logic [W-1:0] mask_q;

   // a clear on the same bit overrides a set
   always_ff @(posedge clk) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= (mask_q | set_i) & ~clr_i & IMPL;
   end

   assign mask_o = mask_q;
endmodule

// File: rtl/card_evt_irq.sv
module card_evt_irq
   import cei_pkg::*;
#(
   parameter int          AW        = 8,
   parameter logic [AW-1:0] OFS_STAT = AW'(DEF_OFS_STAT),
   parameter logic [AW-1:0] OFS_SET  = AW'(DEF_OFS_SET),
   parameter logic [AW-1:0] OFS_CLR  = AW'(DEF_OFS_CLR),
   parameter logic [AW-1:0] OFS_MASK = AW'(DEF_OFS_MASK),
   parameter bit          LIVE_SYNC = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   input  logic [31:0]   evt_in,
   output logic          irq
);
   localparam word_t IMPL_BITS = LIVE_BITS | ERR_BITS;

   if (AW < 3) begin : g_bad_aw
      $error("card_evt_irq: AW too small");
   end
   if ((OFS_STAT[1:0] | OFS_SET[1:0] | OFS_CLR[1:0] | OFS_MASK[1:0]) != 2'b00) begin : g_bad_align
      $error("card_evt_irq: offsets must be word aligned");
   end
   if (OFS_STAT == OFS_SET || OFS_STAT == OFS_CLR || OFS_STAT == OFS_MASK ||
       OFS_SET == OFS_CLR || OFS_SET == OFS_MASK || OFS_CLR == OFS_MASK) begin : g_bad_map
      $error("card_evt_irq: offsets overlap");
   end

   logic  hit_stat, hit_set, hit_clr, hit_mask;
   logic  rd_stat;
   word_t set_vec, clr_vec;
   word_t live_w, sticky_q, mask_q, stat_w;

   assign hit_stat = (bus_addr == OFS_STAT);
   assign hit_set  = (bus_addr == OFS_SET);
   assign hit_clr  = (bus_addr == OFS_CLR);
   assign hit_mask = (bus_addr == OFS_MASK);
   assign rd_stat  = bus_rd && hit_stat;

   assign set_vec = (bus_wr && hit_set) ? bus_wdata : '0;
   assign clr_vec = (bus_wr && hit_clr) ? bus_wdata : '0;

   cei_live #(.W(WORD_W), .KEEP(LIVE_BITS), .SYNC(LIVE_SYNC)) u_live (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (evt_in),
      .lvl_o (live_w)
   );

   cei_sticky #(.W(WORD_W), .KEEP(ERR_BITS)) u_sticky (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_in),
      .clr_i  (rd_stat),
      .flag_o (sticky_q)
   );

   cei_mask #(.W(WORD_W), .IMPL(IMPL_BITS)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (clr_vec),
      .mask_o (mask_q)
   );

   assign stat_w = live_w | sticky_q;
   assign irq    = |(stat_w & mask_q);

   always_ff @(posedge clk) begin
      if (!rst_n || !bus_rd) bus_rdata <= '0;
      else if (hit_stat)     bus_rdata <= stat_w;
      else if (hit_mask)     bus_rdata <= mask_q;
      else                   bus_rdata <= '0;
   end
endmodule

// File: rtl/cei_chk.sv
module cei_chk
   import cei_pkg::*;
#(
   parameter int          AW       = 8,
   parameter logic [AW-1:0] OFS_STAT = AW'(DEF_OFS_STAT),
   parameter logic [AW-1:0] OFS_SET  = AW'(DEF_OFS_SET),
   parameter logic [AW-1:0] OFS_CLR  = AW'(DEF_OFS_CLR),
   parameter logic [AW-1:0] OFS_MASK = AW'(DEF_OFS_MASK)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] bus_addr,
   input logic          bus_wr,
   input logic          bus_rd,
   input logic [31:0]   bus_wdata,
   input logic [31:0]   bus_rdata,
   input logic          irq,
   input logic [31:0]   mask_q,
   input logic [31:0]   sticky_q
);
   localparam word_t IMPL_BITS = LIVE_BITS | ERR_BITS;

   // R5
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_SET) |=>
         ((mask_q & $past(bus_wdata) & IMPL_BITS) == ($past(bus_wdata) & IMPL_BITS)));

   // R5
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_CLR) |=> ((mask_q & $past(bus_wdata)) == 32'h0));

   // R6
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && (bus_addr == OFS_SET || bus_addr == OFS_CLR)) |=> $stable(mask_q));

   // R3
   sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_addr == OFS_STAT) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

   // R4
   read_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == OFS_STAT) |=> (bus_rdata[31:16] == $past(sticky_q[31:16])));

   // R7
   unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rdata & ~IMPL_BITS) == 32'h0));

   // R8
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == 32'h0) |-> !irq);

   // R9
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == 32'h0));
endmodule

bind card_evt_irq cei_chk #(
   .AW(AW), .OFS_STAT(OFS_STAT), .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR), .OFS_MASK(OFS_MASK)
) u_cei_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .mask_q    (mask_q),
   .sticky_q  (sticky_q)
);

// File: tb/card_evt_irq_bench.sv
`timescale 1ns/1ps
module card_evt_irq_bench;
   localparam logic [31:0] LIVE = 32'h0000_C0FF;
   localparam logic [31:0] ERR  = 32'hC07F_0000;
   localparam logic [31:0] IMPL = LIVE | ERR;
   localparam logic [7:0]  A_STAT = 8'h40, A_SET = 8'h44, A_CLR = 8'h48, A_MASK = 8'h4C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] evt_in = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   card_evt_irq u_card_evt_irq (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic pulse(input logic [31:0] v);
      evt_in = v;
      @(negedge clk);
      evt_in = '0;
   endtask

   initial begin
      logic [31:0] d, expm;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 rdata", bus_rdata, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(A_STAT, d); check("R1 status", d, 32'h0);
      rd(A_MASK, d); check("R1 mask", d, 32'h0);

      // R5 set sweep, then R7 on unimplemented positions
      expm = '0;
      for (int i = 0; i < 32; i++) begin
         wr(A_SET, 32'h1 << i);
         expm |= (32'h1 << i) & IMPL;
         rd(A_MASK, d); check("R5/R7 mask set", d, expm);
      end
      // R5 clear sweep
      for (int i = 0; i < 32; i++) begin
         wr(A_CLR, 32'h1 << i);
         expm &= ~(32'h1 << i);
         rd(A_MASK, d); check("R5 mask clear", d, expm);
      end
      wr(A_SET, 32'hFFFF_FFFF);
      rd(A_MASK, d); check("R5/R7 set all", d, IMPL);
      wr(A_CLR, 32'hFFFF_FFFF);
      rd(A_MASK, d); check("R5 clear all", d, 32'h0);

      // R6 writes to status and readback offsets ignored
      wr(A_SET, 32'h0000_0005);
      wr(A_MASK, 32'hFFFF_FFFF);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_MASK, d); check("R6 mask unchanged", d, 32'h0000_0005);
      pulse(32'h0001_0000);
      wr(A_STAT, 32'hFFFF_FFFF);
      wr(A_MASK, 32'h0);
      rd(A_STAT, d); check("R6 sticky kept", d, 32'h0001_0000);
      wr(A_CLR, 32'hFFFF_FFFF);

      // R2 live bits, R7 unused low bits
      for (int i = 0; i < 16; i++) begin
         evt_in = 32'h1 << i;
         rd(A_STAT, d); check("R2/R7 live", d, (32'h1 << i) & LIVE);
         evt_in = '0;
         rd(A_STAT, d); check("R2 not latched", d, 32'h0);
      end

      // R3 capture and hold, R4 clear on read, R7 unused high bits
      for (int i = 16; i < 32; i++) begin
         pulse(32'h1 << i);
         @(negedge clk);
         rd(A_MASK, d); check("R3 other read", d, 32'h0);
         rd(A_STAT, d); check("R3/R4/R7 captured", d, (32'h1 << i) & ERR);
         rd(A_STAT, d); check("R4 cleared", d, 32'h0);
      end

      // R4 collision: error pulse in the cycle of a status read
      pulse(32'h0040_0000);
      bus_addr = A_STAT; bus_rd = 1'b1; evt_in = 32'h8000_0000;
      @(negedge clk);
      d = bus_rdata; bus_rd = 1'b0; evt_in = '0;
      check("R4 collision first read", d, 32'h0040_0000);
      rd(A_STAT, d); check("R4 collision second read", d, 32'h8000_0000);
      rd(A_STAT, d); check("R4 collision drained", d, 32'h0);

      // R8 interrupt per bit
      for (int i = 0; i < 32; i++) begin
         wr(A_SET, 32'h1 << i);
         #1 check("R8 mask alone", {31'h0, irq}, 32'h0);
         if (((32'h1 << i) & LIVE) != 0) begin
            evt_in = 32'h1 << i;
            #1 check("R8 live irq", {31'h0, irq}, 32'h1);
            @(negedge clk);
            evt_in = '0;
            #1 check("R8 live drop", {31'h0, irq}, 32'h0);
         end else begin
            pulse(32'h1 << i);
            #1 check("R8 error irq", {31'h0, irq}, ((32'h1 << i) & ERR) != 0 ? 32'h1 : 32'h0);
            rd(A_STAT, d);
            #1 check("R8 irq after clear", {31'h0, irq}, 32'h0);
         end
         wr(A_CLR, 32'hFFFF_FFFF);
      end
      // R8 error held but masked off, then unmasked
      pulse(32'h0010_0000);
      #1 check("R8 masked error", {31'h0, irq}, 32'h0);
      wr(A_SET, 32'h0010_0000);
      #1 check("R8 unmask error", {31'h0, irq}, 32'h1);
      wr(A_CLR, 32'h0010_0000);
      #1 check("R8 remask", {31'h0, irq}, 32'h0);
      rd(A_STAT, d); check("R8 status kept", d, 32'h0010_0000);

      // R9 write-only and unmapped offsets read zero, idle rdata zero
      wr(A_SET, 32'h0000_00FF);
      rd(A_SET, d); check("R9 set offset", d, 32'h0);
      rd(A_CLR, d); check("R9 clr offset", d, 32'h0);
      rd(8'h50, d); check("R9 unmapped", d, 32'h0);
      rd(A_MASK, d); check("R9 mask path", d, 32'h0000_00FF);
      @(negedge clk);
      check("R9 idle rdata", bus_rdata, 32'h0);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got %08h expected %08h", 32'h0, 32'h1);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule